// File: doc/BRIEF.md
# Fixed-Priority Preemptive Interrupt Controller

This block collects 32 external interrupt lines and hands one interrupt at a time to a processor. Every line has a vector that is wired in and cannot be changed: line n always arrives as vector 32+n. A larger vector always has the higher priority. The block keeps a pending bit and an in-service bit for each line. It raises a request that carries the vector of the best line that may be delivered. A line may be delivered when it is pending, not masked, above the task-priority threshold, and strictly higher than everything already in service.

Nested service is held as a bit vector, not as an explicit stack. When the processor acknowledges a request, that line's bit moves from pending to in-service. An end-of-interrupt strobe retires the highest in-service bit, and the best waiting request can then come forward. A separate register block decodes the bus and drives the strobes and the task-priority write into this block. It also reads back the in-service word and the task-priority value.

Top module: `irqc_top`

## Requirements
- R1: After reset, `intReq` is 0, `intVec` is 0, `isrOut` is all zeros and `tprOut` is 0.
- R2: The vector of line n is fixed at 32+n. `intVec` shows it while `intReq` is high, and `intVec` reads 0 while `intReq` is low.
- R3: When several lines can be delivered at once, the one with the largest line number is presented.
- R4: An `intAck` pulse while `intReq` is high clears the pending bit of the presented line and sets bit n of `isrOut` (bit n is vector 32+n) in the same clock edge.
- R5: A deliverable line with a higher number than the highest set bit of `isrOut` raises `intReq` at once, even while another line is in service.
- R6: A pending line whose number is at or below the highest set bit of `isrOut` stays pending and is not presented. After an `eoiWr` pulse, the best remaining deliverable line is presented.
- R7: An `eoiWr` pulse while `isrOut` is non-zero clears only the highest set bit of `isrOut`.
- R8: An `eoiWr` pulse while `isrOut` is zero discards every latched edge-mode pending bit. A rising edge that arrives on the same clock is still latched.
- R9: When `edgeMode[n]` is 1, line n is rising-edge triggered. A rising edge on a line whose `lineMask` bit is 1 is still latched, but that line is not presented. Once the mask bit is cleared, the line is presented.
- R10: When `edgeMode[n]` is 0, line n is level triggered. It is pending while the input is high and stops being pending once the input goes low.
- R11: A `tprWe` pulse loads `tprWrData`, which reads back on `tprOut`. A vector v is suppressed when v[7:4] <= tpr[7:4].
- R12: An `intAck` pulse while `intReq` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 32 | External interrupt lines |
| lineMask | input | 32 | 1 = line excluded from delivery |
| edgeMode | input | 32 | 1 = rising-edge trigger, 0 = level trigger |
| intAck | input | 1 | Processor accepts the presented vector |
| eoiWr | input | 1 | End-of-interrupt write strobe |
| tprWe | input | 1 | Task-priority write strobe |
| tprWrData | input | 8 | Task-priority write value |
| intReq | output | 1 | Interrupt request to the processor |
| intVec | output | 8 | Presented vector (0 when no request) |
| isrOut | output | 32 | In-service word, bit n = vector 32+n |
| tprOut | output | 8 | Current task priority |

## Verification
Three directed patterns are applied. The first is single edge pulses, which separate the fixed mapping from line to vector. The second is simultaneous edges on mixed lines, which shows whether the priority picks the highest vector or the first one found. The third is a lower line raised while a higher one is in service, set against a higher line raised in the same situation, which separates waiting from preemption. Level-mode holds and drops, masked edges, threshold writes and an end-of-interrupt on an empty in-service word check the capture and suppression paths. A long random phase mixes edges, masks, acknowledges and end-of-interrupt strobes on the same clocks, which exposes any mistake in how colliding strobes are combined.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Strobes from control to datapath, one clock wide each.
  typedef struct packed {
    logic ackFire;     // move presented line from pending to in-service
    logic eoiFire;     // retire highest in-service line
    logic discardAll;  // end-of-interrupt with nothing in service
    logic tprLoad;     // load task priority
  } ctlStrobes_t;

endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int VEC_BASE    = 32,
  parameter int VEC_W       = 8,
  parameter int CLASS_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_LINES-1:0] lineMask,
  input  logic [NUM_LINES-1:0] edgeMode,
  input  logic [VEC_W-1:0]     tprWrData,
  input  ctlStrobes_t          strobes,
  output logic                 reqValid,
  output logic                 isrAny,
  output logic [VEC_W-1:0]     candVec,
  output logic [NUM_LINES-1:0] isrOut,
  output logic [VEC_W-1:0]     tprOut
);

  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] pendReg, isrReg, prevReg;
  logic [VEC_W-1:0]     tprReg;

  logic [NUM_LINES-1:0] classOk, eligible, ackHot, eoiHot, risingHits;
  logic [NUM_LINES-1:0] pendNext, isrNext;
  logic                 candAny;
  logic [IDX_W-1:0]     candIdx, svcIdx;

  // Highest set bit: returns {found, index}.
  function automatic logic [IDX_W:0] topBit(input logic [NUM_LINES-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  // Threshold compare per line, vector class is fixed per line.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_class
    assign classOk[g] = ((VEC_BASE + g) >> CLASS_SHIFT) > int'(tprReg >> CLASS_SHIFT);
  end

  assign eligible   = pendReg & ~lineMask & classOk;
  assign risingHits = irqLines & ~prevReg;

  always_comb begin
    {candAny, candIdx} = topBit(eligible);
    {isrAny, svcIdx}   = topBit(isrReg);
    reqValid = candAny && (!isrAny || (candIdx > svcIdx));
    candVec  = VEC_W'(VEC_BASE + int'(candIdx));

    ackHot = '0;
    if (strobes.ackFire) ackHot[candIdx] = 1'b1;
    eoiHot = '0;
    if (strobes.eoiFire) eoiHot[svcIdx] = 1'b1;

    isrNext = (isrReg & ~eoiHot) | ackHot;

    for (int i = 0; i < NUM_LINES; i++) begin
      if (edgeMode[i])
        pendNext[i] = ((pendReg[i] & ~strobes.discardAll) | risingHits[i]) & ~ackHot[i];
      else
        pendNext[i] = irqLines[i] & ~ackHot[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      isrReg  <= '0;
      prevReg <= '0;
      tprReg  <= '0;
    end else begin
      pendReg <= pendNext;
      isrReg  <= isrNext;
      prevReg <= irqLines;
      if (strobes.tprLoad) tprReg <= tprWrData;
    end
  end

  assign isrOut = isrReg;
  assign tprOut = tprReg;

endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              intAck,
  input  logic              eoiWr,
  input  logic              tprWe,
  input  logic              reqValid,
  input  logic              isrAny,
  input  logic [VEC_W-1:0]  candVec,
  output ctlStrobes_t       strobes,
  output logic              intReq,
  output logic [VEC_W-1:0]  intVec
);

  always_comb begin
    strobes.ackFire    = intAck & reqValid;
    strobes.eoiFire    = eoiWr & isrAny;
    strobes.discardAll = eoiWr & ~isrAny;
    strobes.tprLoad    = tprWe;
    intReq             = reqValid;
    intVec             = reqValid ? candVec : '0;
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int VEC_BASE    = 32,
  parameter int VEC_W       = 8,
  parameter int CLASS_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_LINES-1:0] lineMask,
  input  logic [NUM_LINES-1:0] edgeMode,
  input  logic                 intAck,
  input  logic                 eoiWr,
  input  logic                 tprWe,
  input  logic [VEC_W-1:0]     tprWrData,
  output logic                 intReq,
  output logic [VEC_W-1:0]     intVec,
  output logic [NUM_LINES-1:0] isrOut,
  output logic [VEC_W-1:0]     tprOut
);

  ctlStrobes_t      strobes;
  logic             reqValid, isrAny;
  logic [VEC_W-1:0] candVec;

  irqc_datapath #(
    .NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE),
    .VEC_W(VEC_W), .CLASS_SHIFT(CLASS_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .lineMask(lineMask),
    .edgeMode(edgeMode), .tprWrData(tprWrData), .strobes(strobes),
    .reqValid(reqValid), .isrAny(isrAny), .candVec(candVec),
    .isrOut(isrOut), .tprOut(tprOut)
  );

  irqc_control #(.VEC_W(VEC_W)) u_ctl (
    .intAck(intAck), .eoiWr(eoiWr), .tprWe(tprWe),
    .reqValid(reqValid), .isrAny(isrAny), .candVec(candVec),
    .strobes(strobes), .intReq(intReq), .intVec(intVec)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_LINES = 32,
  parameter int VEC_BASE  = 32,
  parameter int VEC_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intReq,
  input logic [VEC_W-1:0]     intVec,
  input logic                 intAck,
  input logic                 eoiWr,
  input logic [NUM_LINES-1:0] isrOut
);

  localparam int IDX_W = $clog2(NUM_LINES);

  logic [IDX_W-1:0] vecIdx, isrTop;
  logic             isrSet;

  assign vecIdx = IDX_W'(int'(intVec) - VEC_BASE);

  always_comb begin
    isrTop = '0;
    isrSet = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (isrOut[i]) begin
        isrTop = IDX_W'(i);
        isrSet = 1'b1;
      end
    end
  end

  // R2: a presented vector lies in the fixed vector range
  a_r2_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (int'(intVec) >= VEC_BASE) && (int'(intVec) < VEC_BASE + NUM_LINES));

  // R4: acknowledged line appears in service on the next edge
  a_r4_ack_to_isr: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> isrOut[$past(vecIdx)]);

  // R5: a request is always strictly above everything in service
  a_r5_preempt_only_higher: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && isrSet) |-> (vecIdx > isrTop));

  // R7: end-of-interrupt without acknowledge retires exactly one bit
  a_r7_eoi_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    (eoiWr && !intAck && isrSet) |=> ($countones(isrOut) == $countones($past(isrOut)) - 1));

  // R12: acknowledge without request leaves in-service state alone
  a_r12_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq && !eoiWr) |=> $stable(isrOut));

  // R6: in-service state moves only on acknowledge or end-of-interrupt
  a_r6_isr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!intAck && !eoiWr) |=> $stable(isrOut));

endmodule

bind irqc_top irqc_checker #(
  .NUM_LINES(NUM_LINES), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .intReq(intReq), .intVec(intVec),
  .intAck(intAck), .eoiWr(eoiWr), .isrOut(isrOut)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0, lineMask = '0, edgeMode = '1;
  logic        intAck = 1'b0, eoiWr = 1'b0, tprWe = 1'b0;
  logic [7:0]  tprWrData = '0;
  logic        intReq;
  logic [7:0]  intVec;
  logic [31:0] isrOut;
  logic [7:0]  tprOut;

  irqc_top u_irqc_top (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .lineMask(lineMask),
    .edgeMode(edgeMode), .intAck(intAck), .eoiWr(eoiWr), .tprWe(tprWe),
    .tprWrData(tprWrData), .intReq(intReq), .intVec(intVec),
    .isrOut(isrOut), .tprOut(tprOut)
  );

  always #5 clk = ~clk;

  int    nVec = 0, nBad = 0;
  bit    done = 0;
  string curReq = "R1";

  // Reference state
  bit [31:0] mPend, mIsr, mPrev;
  bit [7:0]  mTpr;

  function automatic int highest(bit [31:0] v);
    int k = 31;
    while (k >= 0 && !v[k]) k--;
    return k;
  endfunction

  function automatic bit [31:0] deliverable();
    bit [31:0] e;
    for (int i = 0; i < 32; i++)
      e[i] = mPend[i] && !lineMask[i] && (((32 + i) / 16) > (mTpr / 16));
    return e;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: compare outputs, advance the model, move to the next low phase.
  task automatic tick();
    int h, s;
    bit req, ack;
    bit [31:0] nPend, nIsr;
    #1;
    h = highest(deliverable());
    s = highest(mIsr);
    req = (h >= 0) && (h > s);
    check(curReq, int'(intReq), int'(req), "intReq");
    check(curReq, int'(intVec), req ? 32 + h : 0, "intVec");
    check(curReq, int'(isrOut), int'(mIsr), "isrOut");
    check(curReq, int'(tprOut), int'(mTpr), "tprOut");
    ack = intAck && req;
    nIsr = mIsr;
    if (eoiWr && s >= 0) nIsr[s] = 0;
    if (ack) nIsr[h] = 1;
    for (int i = 0; i < 32; i++) begin
      if (edgeMode[i])
        nPend[i] = ((eoiWr && s < 0) ? 1'b0 : mPend[i]) | (irqLines[i] & ~mPrev[i]);
      else
        nPend[i] = irqLines[i];
      if (ack && i == h) nPend[i] = 0;
    end
    @(posedge clk);
    if (rstN) begin
      mPend = nPend;
      mIsr  = nIsr;
      mPrev = irqLines;
      if (tprWe) mTpr = tprWrData;
    end
    @(negedge clk);
  endtask

  task automatic pulse(int line);
    irqLines[line] = 1'b1; tick();
    irqLines[line] = 1'b0;
  endtask

  task automatic ackOnce();
    intAck = 1'b1; tick(); intAck = 1'b0;
  endtask

  task automatic eoiOnce();
    eoiWr = 1'b1; tick(); eoiWr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    mPend = '0; mIsr = '0; mPrev = '0; mTpr = '0;
    @(negedge clk);
    curReq = "R1";
    tick(); tick();
    rstN = 1'b1;
    tick();
    check("R1", int'(isrOut), 0, "reset isr");

    // R2: fixed mapping, line 5 -> vector 37
    curReq = "R2";
    pulse(5); tick();
    check("R2", int'(intVec), 37, "line5 vector");
    ackOnce(); eoiOnce(); tick();

    // R3 and R6: three lines at once, highest wins, lower wait
    curReq = "R3";
    irqLines[3] = 1; irqLines[20] = 1; irqLines[9] = 1; tick();
    irqLines = '0; tick();
    check("R3", int'(intVec), 52, "highest of three");
    curReq = "R4";
    ackOnce();
    check("R4", int'(isrOut), 32'h0010_0000, "ack sets isr bit 20");
    curReq = "R6";
    tick();
    check("R6", int'(intReq), 0, "lower lines wait");
    eoiOnce();
    check("R6", int'(intVec), 41, "next after eoi");
    ackOnce();

    // R5: line 30 preempts line 9 in service
    curReq = "R5";
    pulse(30); tick();
    check("R5", int'(intVec), 62, "preempt vector");
    ackOnce();
    curReq = "R7";
    eoiOnce();
    check("R7", int'(isrOut), 32'h0000_0200, "only top isr bit cleared");
    eoiOnce(); tick();
    // line 3 still pending -> vector 35
    check("R6", int'(intVec), 35, "remaining pending");
    ackOnce(); eoiOnce();

    // R9: masked edge latched and delivered after unmask
    curReq = "R9";
    lineMask[7] = 1; pulse(7); tick();
    check("R9", int'(intReq), 0, "masked not presented");
    lineMask[7] = 0; tick();
    check("R9", int'(intVec), 39, "unmasked delivered");
    ackOnce(); eoiOnce();

    // R8: stale masked pending discarded by empty-isr eoi
    curReq = "R8";
    lineMask[4] = 1; pulse(4); tick();
    eoiOnce();
    lineMask[4] = 0; tick();
    check("R8", int'(intReq), 0, "discarded pending");

    // R10: level line 12
    curReq = "R10";
    edgeMode[12] = 0; irqLines[12] = 1; tick(); tick();
    check("R10", int'(intVec), 44, "level high");
    irqLines[12] = 0; tick(); tick();
    check("R10", int'(intReq), 0, "level low");
    edgeMode[12] = 1;

    // R11: threshold
    curReq = "R11";
    tprWe = 1; tprWrData = 8'h20; tick(); tprWe = 0;
    check("R11", int'(tprOut), 32, "tpr readback");
    pulse(2); tick();
    check("R11", int'(intReq), 0, "class 2 suppressed");
    pulse(18); tick();
    check("R11", int'(intVec), 50, "class 3 delivered");
    tprWe = 1; tprWrData = 8'h30; tick(); tprWe = 0; tick();
    check("R11", int'(intReq), 0, "all suppressed");
    tprWe = 1; tprWrData = 8'h00; tick(); tprWe = 0; tick();
    ackOnce(); ackOnce(); eoiOnce(); eoiOnce();

    // R12: stray acknowledge
    curReq = "R12";
    eoiOnce(); tick();
    ackOnce();
    check("R12", int'(isrOut), 0, "stray ack ignored");

    // Random mix of everything, model compared every clock
    curReq = "R3";
    for (int c = 0; c < 3000; c++) begin
      irqLines = $urandom & $urandom;
      if (c % 64 == 0) begin
        lineMask = $urandom & $urandom & $urandom;
        edgeMode = ~($urandom & $urandom & $urandom);
      end
      intAck = ($urandom % 3) == 0;
      eoiWr  = ($urandom % 4) == 0;
      tprWe  = ($urandom % 50) == 0;
      tprWrData = ($urandom % 2) ? 8'h00 : 8'($urandom);
      tick();
    end
    intAck = 0; eoiWr = 0; tprWe = 0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule